// File: doc/BRIEF.md
# Class D Driver Power-Up Sequencer

This controller brings two differential, DAC-driven Class D actuator amplifiers into operation and takes them back out. It owns the two 10-bit DAC code outputs and the select value of a clock divider. The divider derives the amplifiers' sync clock from the high-frequency system clock. The controller also drives the two active-high shutdown outputs and stretches the amplifiers' raw fault indications into status flags, with an optional interrupt.

A start request runs a fixed bring-up order:

1. Both DAC codes are parked at 512, the code with zero differential output. On the 10-bit scale the output is 2.5 V × (code − 512)/512.
2. The sync clock is switched on by loading the requested divider select.
3. After one settle wait, both shutdown outputs are released.
4. After a second settle wait, `ready` rises.

A channel can be stopped at any time once it is released. When both channels are stopped, the sync clock is switched off again and the controller returns to idle. Each settle wait lasts `CLK_MHZ*SETTLE_US` system cycles. Each fault stretch lasts `CLK_MHZ*FAULT_NS/1000` system cycles.

Top module: `amp_bringup_ctrl`

## Requirements
- R1: After reset, both DAC codes are 512, `div_sel` is 0, `shdn` is 2'b11, and `ready`, `sync_clk`, `fault_flag` and `fault_irq` are all 0.
- R2: A start request is accepted only in idle and only when `div_sel_req` is nonzero. Both DAC codes become 512 on the cycle before `div_sel` takes the requested value. A start request with `div_sel_req` equal to 0 changes nothing.
- R3: `shdn` goes to 2'b00 exactly SETTLE cycles after `div_sel` becomes nonzero.
- R4: `ready` rises exactly SETTLE cycles after `shdn` is released. `ready` is never high while both channels are shut down.
- R5: DAC code writes (`dac_wr[0]` writes code A, `dac_wr[1]` writes code B) take effect one cycle later when the controller is idle or running. They are ignored while the start sequence runs.
- R6: After release, `stop_req[i]` sets `shdn[i]` on the next cycle. A stopped channel stays stopped until the next start.
- R7: Once both `shdn` bits are set, `div_sel` is 0 and `ready` is 0 on that same cycle, and `sync_clk` is held low from the following cycle.
- R8: With a nonzero select N, `sync_clk` has a period of N+1 system cycles and rises when the divider counter wraps.
- R9: A one-cycle fault on an unmasked channel holds `fault_flag[i]` high for exactly STRETCH cycles, starting the cycle after the fault is sampled.
- R10: A fault is masked while its channel is in shutdown, and also on the cycle its stop request is taken. A masked fault leaves `fault_flag[i]` at 0.
- R11: `fault_irq` is high exactly when `fault_irq_en` is 1 and either fault flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (high-frequency oscillator) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Pulse that requests the bring-up sequence |
| div_sel_req | input | 3 | Divider select to load during bring-up; 0 is rejected |
| stop_req | input | 2 | Per-channel shutdown request |
| dac_wr | input | 2 | Write strobes for DAC code A (bit 0) and code B (bit 1) |
| dac_wdata_a | input | 10 | New code for DAC A |
| dac_wdata_b | input | 10 | New code for DAC B |
| fault_raw | input | 2 | Raw per-channel fault indication from the amplifiers |
| fault_irq_en | input | 1 | Enables the fault interrupt |
| dac_code_a | output | 10 | Code driven to DAC A |
| dac_code_b | output | 10 | Code driven to DAC B |
| div_sel | output | 3 | Active divider select; 0 means the sync clock is off |
| sync_clk | output | 1 | Divided amplifier sync clock |
| shdn | output | 2 | Active-high amplifier shutdown, one bit per channel |
| ready | output | 1 | High once bring-up has completed |
| fault_flag | output | 2 | Stretched per-channel fault status |
| fault_irq | output | 1 | Fault interrupt |

## Verification
The case that collides is a fault pulse arriving on the same cycle as the stop request for that channel. The stop turns into a shutdown and the fault tries to load the stretch counter. The bench drives both inputs on one channel in a single cycle while the other channel keeps running. It then expects `shdn` to show only that channel stopped, its `fault_flag` to stay at 0, and `div_sel` and `ready` to be unchanged. A second collision is a write to the DAC codes while the parking step is in progress. The parked value of 512 must win there, and the bench checks this during the first settle wait.

// File: rtl/amp_seq_pkg.sv
package amp_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_PARK  = 3'd1,
    SQ_CLKON = 3'd2,
    SQ_WAITA = 3'd3,
    SQ_WAITB = 3'd4,
    SQ_RUN   = 3'd5
  } seq_state_t;

endpackage

// File: rtl/amp_seq_fsm.sv
module amp_seq_fsm
  import amp_seq_pkg::*;
#(
  parameter int DAC_W  = 10,
  parameter int SEL_W  = 3,
  parameter int SETTLE = 25000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [SEL_W-1:0] div_sel_req,
  input  logic [1:0]       stop_req,
  input  logic [1:0]       dac_wr,
  input  logic [DAC_W-1:0] dac_wdata_a,
  input  logic [DAC_W-1:0] dac_wdata_b,
  output logic [DAC_W-1:0] dac_code_a,
  output logic [DAC_W-1:0] dac_code_b,
  output logic [SEL_W-1:0] div_sel,
  output logic [1:0]       shdn,
  output logic [1:0]       shdn_next,
  output logic             ready
);

  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [DAC_W-1:0] MIDCODE = DAC_W'(1) << (DAC_W - 1);
  localparam logic [CW-1:0]    LAST    = CW'(SETTLE - 1);

  seq_state_t       st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [SEL_W-1:0] hold_q, hold_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [1:0]       sd_q, sd_d;
  logic [DAC_W-1:0] ca_q, ca_d, cb_q, cb_d;
  logic             wr_open;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    hold_d = hold_q;
    sel_d  = sel_q;
    sd_d   = sd_q;
    ca_d   = ca_q;
    cb_d   = cb_q;
    wr_open = (st_q == SQ_IDLE) || (st_q == SQ_RUN);
    if (wr_open && dac_wr[0]) ca_d = dac_wdata_a;
    if (wr_open && dac_wr[1]) cb_d = dac_wdata_b;
    case (st_q)
      SQ_IDLE: begin
        if (start_req && (div_sel_req != '0)) begin
          hold_d = div_sel_req;
          st_d   = SQ_PARK;
        end
      end
      SQ_PARK: begin
        ca_d = MIDCODE;
        cb_d = MIDCODE;
        st_d = SQ_CLKON;
      end
      SQ_CLKON: begin
        sel_d = hold_q;
        cnt_d = '0;
        st_d  = SQ_WAITA;
      end
      SQ_WAITA: begin
        if (cnt_q == LAST) begin
          cnt_d = '0;
          sd_d  = 2'b00;
          st_d  = SQ_WAITB;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SQ_WAITB, SQ_RUN: begin
        sd_d = sd_q | stop_req;
        if (sd_d == 2'b11) begin
          sel_d = '0;
          cnt_d = '0;
          st_d  = SQ_IDLE;
        end else if (st_q == SQ_WAITB) begin
          if (cnt_q == LAST) begin
            cnt_d = '0;
            st_d  = SQ_RUN;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        st_d  = SQ_IDLE;
        sel_d = '0;
        sd_d  = 2'b11;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cnt_q  <= '0;
      hold_q <= '0;
      sel_q  <= '0;
      sd_q   <= 2'b11;
      ca_q   <= MIDCODE;
      cb_q   <= MIDCODE;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      sel_q  <= sel_d;
      sd_q   <= sd_d;
      ca_q   <= ca_d;
      cb_q   <= cb_d;
    end
  end

  assign dac_code_a = ca_q;
  assign dac_code_b = cb_q;
  assign div_sel    = sel_q;
  assign shdn       = sd_q;
  assign shdn_next  = sd_d;
  assign ready      = (st_q == SQ_RUN);

  AST_PARK_BEFORE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel_q) == '0 && sel_q != '0) |-> (ca_q == MIDCODE && cb_q == MIDCODE)); // R2
  AST_CLK_OFF_IN_SHDN: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == '0) |-> (sd_q == 2'b11)); // R7
  AST_READY_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (sd_q != 2'b11)); // R4
  AST_SHDN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && stop_req[0]) |=> shdn[0]); // R6

endmodule

// File: rtl/amp_sync_div.sv
module amp_sync_div #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             sync_clk
);

  logic [SEL_W-1:0] cnt_q, cnt_d;
  logic             out_q, out_d;
  logic [SEL_W:0]   half;
  logic [SEL_W:0]   cnt_inc;

  always_comb begin
    half    = ({1'b0, sel} + (SEL_W+1)'(2)) >> 1;
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    if (sel == '0) begin
      cnt_d = '0;
      out_d = 1'b0;
    end else if (cnt_q == sel) begin
      cnt_d = '0;
      out_d = 1'b1;
    end else begin
      cnt_d = cnt_inc[SEL_W-1:0];
      out_d = (cnt_inc < half);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign sync_clk = out_q;

  AST_SYNC_LOW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |=> !sync_clk); // R7
  AST_DIV_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != '0) |-> (cnt_q <= sel)); // R8

endmodule

// File: rtl/amp_fault_stretch.sv
module amp_fault_stretch #(
  parameter int STRETCH = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic mask,
  output logic flag
);

  localparam int FW = $clog2(STRETCH + 1);

  logic [FW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (mask)               cnt_d = '0;
    else if (raw)           cnt_d = FW'(STRETCH);
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign flag = (cnt_q != '0);

  AST_FAULT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    mask |=> !flag); // R10
  AST_FAULT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (raw && !mask) |=> flag); // R9

endmodule

// File: rtl/amp_bringup_ctrl.sv
module amp_bringup_ctrl #(
  parameter int CLK_MHZ   = 250,
  parameter int SETTLE_US = 100,
  parameter int FAULT_NS  = 500,
  parameter int DAC_W     = 10,
  parameter int SEL_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [SEL_W-1:0] div_sel_req,
  input  logic [1:0]       stop_req,
  input  logic [1:0]       dac_wr,
  input  logic [DAC_W-1:0] dac_wdata_a,
  input  logic [DAC_W-1:0] dac_wdata_b,
  input  logic [1:0]       fault_raw,
  input  logic             fault_irq_en,
  output logic [DAC_W-1:0] dac_code_a,
  output logic [DAC_W-1:0] dac_code_b,
  output logic [SEL_W-1:0] div_sel,
  output logic             sync_clk,
  output logic [1:0]       shdn,
  output logic             ready,
  output logic [1:0]       fault_flag,
  output logic             fault_irq
);

  localparam int SETTLE  = CLK_MHZ * SETTLE_US;
  localparam int STRETCH = (CLK_MHZ * FAULT_NS + 999) / 1000;

  logic [1:0] shdn_next;

  amp_seq_fsm #(.DAC_W(DAC_W), .SEL_W(SEL_W), .SETTLE(SETTLE)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_req   (start_req),
    .div_sel_req (div_sel_req),
    .stop_req    (stop_req),
    .dac_wr      (dac_wr),
    .dac_wdata_a (dac_wdata_a),
    .dac_wdata_b (dac_wdata_b),
    .dac_code_a  (dac_code_a),
    .dac_code_b  (dac_code_b),
    .div_sel     (div_sel),
    .shdn        (shdn),
    .shdn_next   (shdn_next),
    .ready       (ready)
  );

  amp_sync_div #(.SEL_W(SEL_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (div_sel),
    .sync_clk (sync_clk)
  );

  for (genvar ch = 0; ch < 2; ch++) begin : g_fault
    amp_fault_stretch #(.STRETCH(STRETCH)) u_fs (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (fault_raw[ch]),
      .mask  (shdn_next[ch]),
      .flag  (fault_flag[ch])
    );
  end

  assign fault_irq = fault_irq_en & (|fault_flag);

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_irq |-> fault_irq_en); // R11

endmodule

// File: tb/tb_amp_bringup_ctrl.sv
module tb_amp_bringup_ctrl;

  localparam int CLK_MHZ = 250;
  localparam int SET_US  = 1;
  localparam int LIM     = CLK_MHZ * SET_US;
  localparam int STR     = (CLK_MHZ * 500 + 999) / 1000;

  logic clk, rst_n, start_req, fault_irq_en;
  logic [2:0] div_sel_req, div_sel;
  logic [1:0] stop_req, dac_wr, fault_raw, shdn, fault_flag;
  logic [9:0] dac_wdata_a, dac_wdata_b, dac_code_a, dac_code_b;
  logic sync_clk, ready, fault_irq;

  amp_bringup_ctrl #(.CLK_MHZ(CLK_MHZ), .SETTLE_US(SET_US)) dut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .div_sel_req(div_sel_req),
    .stop_req(stop_req), .dac_wr(dac_wr), .dac_wdata_a(dac_wdata_a),
    .dac_wdata_b(dac_wdata_b), .fault_raw(fault_raw), .fault_irq_en(fault_irq_en),
    .dac_code_a(dac_code_a), .dac_code_b(dac_code_b), .div_sel(div_sel),
    .sync_clk(sync_clk), .shdn(shdn), .ready(ready), .fault_flag(fault_flag),
    .fault_irq(fault_irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct { string req; int sig; int exp; } item_t;
  item_t exp_q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  function automatic int observe(int sig);
    case (sig)
      0: return int'(dac_code_a);
      1: return int'(dac_code_b);
      2: return int'(div_sel);
      3: return int'(shdn);
      4: return int'(ready);
      5: return int'(fault_flag);
      6: return int'(fault_irq);
      default: return int'(sync_clk);
    endcase
  endfunction

  // monitor: pops expected items and compares with the port values
  initial begin
    forever begin
      wait (exp_q.size() > 0);
      begin
        item_t it;
        int act;
        it  = exp_q.pop_front();
        act = observe(it.sig);
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s signal %0d: actual %0d expected %0d", it.req, it.sig, act, it.exp);
        end
      end
    end
  end

  task automatic expect_sig(string req, int sig, int exp);
    item_t it;
    it.req = req; it.sig = sig; it.exp = exp;
    exp_q.push_back(it);
    wait (exp_q.size() == 0);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    int rises;
    logic prev;
    rst_n = 0; start_req = 0; div_sel_req = 0; stop_req = 0; dac_wr = 0;
    dac_wdata_a = 0; dac_wdata_b = 0; fault_raw = 0; fault_irq_en = 0;
    tick(3);
    // R1 reset state
    expect_sig("R1", 0, 512); expect_sig("R1", 1, 512); expect_sig("R1", 2, 0);
    expect_sig("R1", 3, 3);   expect_sig("R1", 4, 0);   expect_sig("R1", 5, 0);
    expect_sig("R1", 6, 0);   expect_sig("R1", 7, 0);
    rst_n = 1;
    tick(2);
    // R5 idle write accepted
    dac_wr = 2'b11; dac_wdata_a = 10'd100; dac_wdata_b = 10'd900;
    tick(1); dac_wr = 0;
    expect_sig("R5", 0, 100); expect_sig("R5", 1, 900);
    // R2 start with select 3
    start_req = 1; div_sel_req = 3'd3;
    tick(1); start_req = 0;
    tick(1);
    expect_sig("R2", 0, 512); expect_sig("R2", 1, 512); expect_sig("R2", 2, 0);
    tick(1);
    expect_sig("R2", 2, 3); expect_sig("R3", 3, 3);
    // k = 0 cycles since div_sel loaded
    dac_wr = 2'b01; dac_wdata_a = 10'd7;
    tick(1); dac_wr = 0;                        // k = 1
    expect_sig("R5", 0, 512);
    fault_raw = 2'b11; fault_irq_en = 1;
    tick(1); fault_raw = 0;                     // k = 2
    tick(1);                                    // k = 3
    expect_sig("R10", 5, 0);
    tick(LIM - 4);                              // k = LIM-1
    expect_sig("R3", 3, 3);
    tick(1);
    expect_sig("R3", 3, 0); expect_sig("R4", 4, 0);
    tick(LIM - 1);
    expect_sig("R4", 4, 0);
    tick(1);
    expect_sig("R4", 4, 1);
    // R8 period 4 with select 3: 10 rises in 40 cycles
    rises = 0; prev = sync_clk;
    for (int i = 0; i < 40; i++) begin
      tick(1);
      if (sync_clk && !prev) rises++;
      prev = sync_clk;
    end
    n_chk++;
    if (rises != 10) begin
      n_fail++;
      $display("FAIL R8 sync rises: actual %0d expected %0d", rises, 10);
    end
    // R5 run write accepted
    dac_wr = 2'b01; dac_wdata_a = 10'd300;
    tick(1); dac_wr = 0;
    expect_sig("R5", 0, 300);
    // R9 / R11 stretch with irq enabled
    fault_raw = 2'b10;
    tick(1); fault_raw = 0;
    expect_sig("R9", 5, 2); expect_sig("R11", 6, 1);
    tick(STR - 1);
    expect_sig("R9", 5, 2);
    tick(1);
    expect_sig("R9", 5, 0); expect_sig("R11", 6, 0);
    // R11 irq disabled
    fault_irq_en = 0; fault_raw = 2'b10;
    tick(1); fault_raw = 0;
    expect_sig("R11", 5, 2); expect_sig("R11", 6, 0);
    tick(STR + 1);
    // R10 / R6 stop and fault in the same cycle on channel 0
    stop_req = 2'b01; fault_raw = 2'b01;
    tick(1); stop_req = 0; fault_raw = 0;
    expect_sig("R6", 3, 1); expect_sig("R10", 5, 0);
    expect_sig("R6", 2, 3); expect_sig("R6", 4, 1);
    tick(1);
    expect_sig("R10", 5, 0);
    // R7 stop channel 1
    stop_req = 2'b10;
    tick(1); stop_req = 0;
    expect_sig("R7", 3, 3); expect_sig("R7", 2, 0); expect_sig("R7", 4, 0);
    tick(1);
    expect_sig("R7", 7, 0);
    tick(3);
    expect_sig("R7", 7, 0);
    // R2 start with select 0 ignored
    start_req = 1; div_sel_req = 3'd0;
    tick(1); start_req = 0;
    tick(3);
    expect_sig("R2", 2, 0); expect_sig("R2", 0, 300); expect_sig("R2", 3, 3);
    // R6 / R7 restart with select 1 and stop both during second wait
    start_req = 1; div_sel_req = 3'd1;
    tick(1); start_req = 0;
    tick(2);
    expect_sig("R2", 2, 1);
    tick(LIM);
    expect_sig("R3", 3, 0);
    tick(5);
    expect_sig("R4", 4, 0);
    stop_req = 2'b11;
    tick(1); stop_req = 0;
    expect_sig("R7", 3, 3); expect_sig("R7", 2, 0); expect_sig("R7", 4, 0);
    tick(LIM + 2);
    expect_sig("R6", 3, 3); expect_sig("R4", 4, 0);
    done = 1;
    finish_run();
  end

endmodule